// File: doc/BRIEF.md
# Keyed Register Write-Protect Lock

This unit sits between the byte-level front end of a serial-bus target and a small file of 16-bit configuration and limit registers. The front end hands over a register pointer byte, then data bytes one at a time, each with a strobe, and signals when a transfer ends. For each byte the unit decides whether to acknowledge it. For each completed pair of data bytes it decides whether the addressed register is updated.

Protection is switched by writing one of two 16-bit key values to a dedicated lock register at address 0xC4. One key arms the protection and the other disarms it. The unit leaves reset armed. While armed, data bytes aimed at a protected register are refused at the acknowledge level and never reach the register. Registers flagged as unprotected, and the lock register itself, stay writable at all times. Reads pass through without change, and the lock register reports the current state.

Top module: `lock_guard_top`

## Requirements
- R1: After reset the unit is locked, a read of address 0xC4 returns 0x8000, and the register at address i (0 to 7) reads 0x1000 + 0x0111×i.
- R2: A completed write of 0xEB19 to address 0xC4 unlocks the unit, after which 0xC4 reads 0x0000.
- R3: A completed write of 0x5CA6 to address 0xC4 locks the unit, after which 0xC4 reads 0x8000.
- R4: A write to 0xC4 of any other value leaves the lock state unchanged, and its data bytes are acknowledged.
- R5: While locked, a write to a lockable register (addresses 0x02 to 0x07 by default) leaves its contents unchanged.
- R6: While locked, data bytes aimed at a lockable register are not acknowledged; the pointer byte is always acknowledged in the cycle of its strobe.
- R7: Non-lockable registers (addresses 0x00 and 0x01 by default) are written and acknowledged whatever the lock state.
- R8: Data arrive most-significant byte first; a register changes only in the clock edge of its second accepted byte, taking {first byte, second byte}.
- R9: A transfer that ends after a single data byte changes nothing, and the next transfer starts again with a most-significant byte.
- R10: Reads are not affected by the lock state; every address reads its current contents.
- R11: A reset returns every register to its default value and the unit to the locked state, whatever the state before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ptrValid | input | 1 | Pointer byte strobe |
| ptrByte | input | 8 | Register address for the transfer |
| dataValid | input | 1 | Data byte strobe |
| dataByte | input | 8 | Data byte, most significant first |
| xferEnd | input | 1 | Transfer end marker |
| byteAck | output | 1 | Acknowledge for the byte strobed in this cycle |
| rdAddr | input | 8 | Read address |
| rdData | output | 16 | Read data for rdAddr |

## Verification
On every cycle the assertions check that no committed write reaches a lockable register while locked, that the pointer byte is always acknowledged, that the lock state moves only on a completed key write and moves the right way, and that no register changes without a write strobe. Only the bench scenarios show that a refused write leaves the register visibly unchanged, that the most-significant byte comes first, that a one-byte transfer is discarded and does not shift the next one, and that a reset restores defaults after changes.

// File: rtl/lockGuardPkg.sv
package lockGuardPkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
  } wrStrobeT;

  function automatic logic [DATA_W-1:0] defaultValue(input int idx);
    return DATA_W'(32'h1000 + 32'h0111 * idx);
  endfunction
endpackage

// File: rtl/lock_guard_ctrl.sv
module lock_guard_ctrl
  import lockGuardPkg::*;
#(
  parameter int                  NUM_REGS   = 8,
  parameter logic [NUM_REGS-1:0] LOCK_MASK  = 8'hFC,
  parameter logic [ADDR_W-1:0]   LOCK_ADDR  = 8'hC4,
  parameter logic [DATA_W-1:0]   LOCK_KEY   = 16'h5CA6,
  parameter logic [DATA_W-1:0]   UNLOCK_KEY = 16'hEB19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptrValid,
  input  logic [ADDR_W-1:0] ptrByte,
  input  logic              dataValid,
  input  logic [7:0]        dataByte,
  input  logic              xferEnd,
  output logic              byteAck,
  output logic              locked,
  output wrStrobeT          strobe
);
  localparam int BYTE_W = 8;

  logic [ADDR_W-1:0] ptr;
  logic              lowPhase;
  logic [BYTE_W-1:0] hold;
  logic              guard;
  logic              accept;
  logic              setLock;
  logic              clrLock;

  function automatic logic lockableAt(input logic [ADDR_W-1:0] a);
    logic hit;
    hit = 1'b0;
    for (int i = 0; i < NUM_REGS; i++)
      if (a == ADDR_W'(i) && LOCK_MASK[i]) hit = 1'b1;
    return hit;
  endfunction

  always_comb begin
    guard   = locked && lockableAt(ptr);
    accept  = dataValid && !ptrValid && !guard;
    byteAck = ptrValid || accept;
    strobe.wrEn   = accept && lowPhase;
    strobe.wrAddr = ptr;
    strobe.wrData = {hold, dataByte};
    setLock = strobe.wrEn && ptr == LOCK_ADDR && strobe.wrData == LOCK_KEY;
    clrLock = strobe.wrEn && ptr == LOCK_ADDR && strobe.wrData == UNLOCK_KEY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked   <= 1'b1;
      ptr      <= '0;
      lowPhase <= 1'b0;
      hold     <= '0;
    end else begin
      if (ptrValid) begin
        ptr      <= ptrByte;
        lowPhase <= 1'b0;
      end else if (accept) begin
        if (!lowPhase) hold <= dataByte;
        lowPhase <= !lowPhase;
      end else if (xferEnd) begin
        lowPhase <= 1'b0;
      end
      if (setLock)      locked <= 1'b1;
      else if (clrLock) locked <= 1'b0;
    end
  end

  // R5: no commit reaches a protected register while locked
  a_r5_no_locked_commit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> !(locked && lockableAt(strobe.wrAddr)));

  // R6: pointer bytes are always acknowledged
  a_r6_ptr_acked: assert property (@(posedge clk) disable iff (!rstN)
    ptrValid |-> byteAck);

  // R2: unlock key clears the lock on the next cycle
  a_r2_unlock: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrAddr == LOCK_ADDR && strobe.wrData == UNLOCK_KEY) |=> !locked);

  // R3: lock key sets the lock on the next cycle
  a_r3_lock: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.wrAddr == LOCK_ADDR && strobe.wrData == LOCK_KEY) |=> locked);

  // R4: lock state holds without a key write
  a_r4_lock_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.wrAddr == LOCK_ADDR &&
      (strobe.wrData == LOCK_KEY || strobe.wrData == UNLOCK_KEY)) |=> $stable(locked));
endmodule

// File: rtl/lock_guard_regfile.sv
module lock_guard_regfile
  import lockGuardPkg::*;
#(
  parameter int                NUM_REGS  = 8,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hC4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobeT          strobe,
  input  logic              locked,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        regs[g] <= defaultValue(g);
      else if (strobe.wrEn && strobe.wrAddr == ADDR_W'(g))
        regs[g] <= strobe.wrData;
    end

    // R8: a register changes only under a write strobe
    a_r8_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.wrEn && strobe.wrAddr == ADDR_W'(g)) |=> $stable(regs[g]));
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == LOCK_ADDR) rdData = {locked, {(DATA_W-1){1'b0}}};
    for (int i = 0; i < NUM_REGS; i++)
      if (rdAddr == ADDR_W'(i)) rdData = regs[i];
  end
endmodule

// File: rtl/lock_guard_top.sv
module lock_guard_top
  import lockGuardPkg::*;
#(
  parameter int                  NUM_REGS   = 8,
  parameter logic [NUM_REGS-1:0] LOCK_MASK  = 8'hFC,
  parameter logic [ADDR_W-1:0]   LOCK_ADDR  = 8'hC4,
  parameter logic [DATA_W-1:0]   LOCK_KEY   = 16'h5CA6,
  parameter logic [DATA_W-1:0]   UNLOCK_KEY = 16'hEB19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ptrValid,
  input  logic [7:0]        ptrByte,
  input  logic              dataValid,
  input  logic [7:0]        dataByte,
  input  logic              xferEnd,
  output logic              byteAck,
  input  logic [7:0]        rdAddr,
  output logic [15:0]       rdData
);
  wrStrobeT strobe;
  logic     locked;

  lock_guard_ctrl #(
    .NUM_REGS(NUM_REGS), .LOCK_MASK(LOCK_MASK), .LOCK_ADDR(LOCK_ADDR),
    .LOCK_KEY(LOCK_KEY), .UNLOCK_KEY(UNLOCK_KEY)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .ptrValid(ptrValid), .ptrByte(ptrByte),
    .dataValid(dataValid), .dataByte(dataByte), .xferEnd(xferEnd),
    .byteAck(byteAck), .locked(locked), .strobe(strobe)
  );

  lock_guard_regfile #(
    .NUM_REGS(NUM_REGS), .LOCK_ADDR(LOCK_ADDR)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .locked(locked),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/sim_lock_guard_top.sv
module sim_lock_guard_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ptrValid = 1'b0, dataValid = 1'b0, xferEnd = 1'b0;
  logic [7:0] ptrByte = '0, dataByte = '0, rdAddr = '0;
  logic byteAck;
  logic [15:0] rdData;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // reference model state
  int mRegs [8];
  bit mLocked;
  int mPtr;
  bit mPhase;
  int mHold;

  always #(PERIOD/2) clk = ~clk;

  lock_guard_top u0 (
    .clk(clk), .rstN(rstN), .ptrValid(ptrValid), .ptrByte(ptrByte),
    .dataValid(dataValid), .dataByte(dataByte), .xferEnd(xferEnd),
    .byteAck(byteAck), .rdAddr(rdAddr), .rdData(rdData)
  );

  function automatic bit mLockable(int a);
    return a >= 2 && a <= 7;
  endfunction

  function automatic int mRead(int a);
    if (a >= 0 && a < 8) return mRegs[a];
    if (a == 'hC4) return mLocked ? 'h8000 : 0;
    return 0;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 8; i++) mRegs[i] = 'h1000 + 'h0111 * i;
    mLocked = 1; mPtr = 0; mPhase = 0; mHold = 0;
  endtask

  task automatic check(string tag, int act, int exp, string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare before posedge, advance model at posedge
  task automatic step(string tag, bit pv, bit dv, bit ev, int b, int ra);
    bit expAck;
    int val;
    @(negedge clk);
    ptrValid = pv; dataValid = dv; xferEnd = ev;
    ptrByte = 8'(b); dataByte = 8'(b); rdAddr = 8'(ra);
    #1;
    expAck = pv || (dv && !(mLocked && mLockable(mPtr)));
    check(tag, int'(byteAck), int'(expAck), "ack");
    check(tag, int'(rdData), mRead(ra), "read");
    @(posedge clk);
    if (pv) begin
      mPtr = b; mPhase = 0;
    end else if (dv && expAck) begin
      if (!mPhase) begin
        mHold = b; mPhase = 1;
      end else begin
        mPhase = 0;
        val = (mHold << 8) | b;
        if (mPtr < 8) mRegs[mPtr] = val;
        if (mPtr == 'hC4 && val == 'h5CA6) mLocked = 1;
        if (mPtr == 'hC4 && val == 'hEB19) mLocked = 0;
      end
    end else if (ev) mPhase = 0;
  endtask

  task automatic write16(string tag, int a, int v);
    step(tag, 1, 0, 0, a, a);
    step(tag, 0, 1, 0, (v >> 8) & 'hFF, a);
    step(tag, 0, 1, 0, v & 'hFF, a);
    step(tag, 0, 0, 1, 0, a);
  endtask

  task automatic readAll(string tag);
    for (int i = 0; i < 8; i++) step(tag, 0, 0, 0, 0, i);
    step(tag, 0, 0, 0, 0, 'hC4);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 0;
    modelReset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    modelReset();
    doReset();
    // R1: reset state
    readAll("R1");
    check("R1", int'(rdData), 'h8000, "lock readback");
    // R5, R6: locked write to protected register refused
    write16("R6", 3, 'hABCD);
    step("R5", 0, 0, 0, 0, 3);
    check("R5", int'(rdData), 'h1333, "reg3 unchanged");
    // R7: non-lockable register written while locked
    write16("R7", 0, 'h4321);
    step("R7", 0, 0, 0, 0, 0);
    check("R7", int'(rdData), 'h4321, "reg0 written");
    // R4: bogus key acknowledged, lock unchanged
    write16("R4", 'hC4, 'h1234);
    step("R4", 0, 0, 0, 0, 'hC4);
    check("R4", int'(rdData), 'h8000, "still locked");
    // R2: unlock key
    write16("R2", 'hC4, 'hEB19);
    step("R2", 0, 0, 0, 0, 'hC4);
    check("R2", int'(rdData), 'h0000, "unlocked");
    // R8: MSB first, commit on second byte only
    step("R8", 1, 0, 0, 3, 3);
    step("R8", 0, 1, 0, 'hBE, 3);
    step("R8", 0, 1, 0, 'hEF, 3);
    check("R8", int'(rdData), 'h1333, "no change before second edge");
    step("R8", 0, 0, 1, 0, 3);
    check("R8", int'(rdData), 'hBEEF, "committed");
    // R9: one-byte transfer discarded, next starts fresh
    step("R9", 1, 0, 0, 4, 4);
    step("R9", 0, 1, 0, 'h11, 4);
    step("R9", 0, 0, 1, 0, 4);
    check("R9", int'(rdData), 'h1444, "one byte ignored");
    write16("R9", 4, 'h2233);
    step("R9", 0, 0, 0, 0, 4);
    check("R9", int'(rdData), 'h2233, "fresh transfer");
    // R3: lock key
    write16("R3", 'hC4, 'h5CA6);
    step("R3", 0, 0, 0, 0, 'hC4);
    check("R3", int'(rdData), 'h8000, "locked again");
    write16("R5", 7, 'h0F0F);
    write16("R7", 1, 'h5555);
    // R10: reads unaffected by lock
    readAll("R10");
    // R11: reset restores defaults and lock
    doReset();
    readAll("R11");
    step("R11", 0, 0, 0, 0, 3);
    check("R11", int'(rdData), 'h1333, "default after reset");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule